// File: doc/BRIEF.md
# I2C Burst Memory Master

This block is a single-master I2C controller that moves a burst of bytes to or from a byte-addressed memory device on the bus. It drives SCL directly and pulls SDA low through an open-drain enable. A one-cycle `start` pulse launches a burst, and the `mode` input chosen at that moment selects the operation. A write sends the device address with the write bit, one memory address byte, and then a fixed number of payload bytes. A read sends the device address, the memory address, a repeated START and the device address with the read bit, then clocks back the same fixed number of bytes.

Payload for a write comes from `wr_data`. The first byte must already be present when `start` is pulsed. Each time the block captures a payload byte it raises `wr_req` for one cycle, and the data source moves on to the next byte in response. Bytes from a read are presented on `rd_data`, each with a one-cycle `rd_valid` strobe. Every burst finishes with a STOP and a one-cycle `done` pulse, including bursts that were aborted.

The SCL period is four quarter phases of `QUARTER` system clocks each. With the defaults (125 clocks per quarter on a 50 MHz clock), SCL runs at 100 kHz. Within each bit, SDA changes in the first quarter (SCL low) and is sampled at the start of the third quarter (SCL high).

Top module: `i2c_burst_master`

## Requirements
- R1: While `rst` is high and in the cycle after it, `scl` is 1, `sda_pull` is 0, and `done`, `wr_req` and `rd_valid` are 0.
- R2: Each burst opens with SDA falling while SCL is high (START) and closes with SDA rising while SCL is high (STOP). The bus is left released between bursts.
- R3: Inside a burst, rising SCL edges are exactly 4*QUARTER cycles apart. The master never changes `sda_pull` in a cycle in which `scl` also changes.
- R4: A write burst carries, MSB first, the bytes 0xA0 (device address 7'b1010000 with write bit 0), `mem_addr`, and then BURST_LEN payload bytes, with the slave's ACK bit after each byte.
- R5: `wr_req` is a one-cycle pulse, issued once per payload byte. The first payload byte is the `wr_data` value held at `start`, and each later byte is the `wr_data` value present when it is loaded, after the previous pulse.
- R6: A read burst carries 0xA0, `mem_addr`, a repeated START and 0xA1 (read bit 1). It then returns BURST_LEN bytes on `rd_data`, each flagged by a one-cycle `rd_valid` pulse.
- R7: In the ninth clock of each read byte, the master drives SDA low (ACK) for every byte except the last, where it releases SDA (NACK) and then issues STOP.
- R8: If the slave does not acknowledge (SDA high in the ninth clock) the device address or the memory address byte, the master issues STOP, transfers no payload (no `wr_req`, no `rd_valid`) and still pulses `done`.
- R9: `done` is a one-cycle pulse after the STOP, and in that cycle `scl` is 1 and `sda_pull` is 0.
- R10: Bytes written by a burst to a start address are returned in the same order by a read burst from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches a burst while idle |
| mode | input | 1 | 0 selects a write burst, 1 selects a read burst (sampled with `start`) |
| mem_addr | input | 8 | Memory start address sent after the device address (sampled with `start`) |
| wr_data | input | 8 | Current payload byte for writes |
| wr_req | output | 1 | One-cycle pulse when a payload byte has been taken |
| rd_data | output | 8 | Last byte read from the slave |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` holds a new byte |
| done | output | 1 | One-cycle pulse at the end of every burst |
| scl | output | 1 | Serial clock, driven by the master |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Resolved level of the SDA line |

## Verification
The checker watches, on every cycle, that SDA and SCL never move in the same cycle. It also checks that `done`, `wr_req` and `rd_valid` are single-cycle pulses, that the bus is free whenever `done` fires, and that reset leaves the bus released. The bench pairs the block with a memory-device model that decodes the bus. Only through that model can the byte order, the repeated START, the master's ACK and NACK pattern, the SCL period, the abort on an unacknowledged address and the write-then-read round trip be shown.

// File: rtl/i2c_burst_master.sv
module i2c_burst_master #(
  parameter int QUARTER = 125,
  parameter int BURST_LEN = 10,
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mode,
  input  logic [7:0] mem_addr,
  input  logic [7:0] wr_data,
  output logic       wr_req,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       done,
  output logic       scl,
  output logic       sda_pull,
  input  logic       sda_in
);
  localparam int QW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam int CW = $clog2(BURST_LEN + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEVW, S_MADDR, S_WDATA, S_RSTART, S_DEVR, S_RDATA, S_STOP
  } st_t;

  st_t           st;
  logic [QW-1:0] qcnt;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic [7:0]    addr_q;
  logic [CW-1:0] cnt;
  logic          ack_n, rd_mode;

  wire tick     = (qcnt == QW'(QUARTER - 1));
  wire slot_end = tick && (q == 2'd3);
  wire mid      = tick && (q == 2'd1);
  wire last     = (cnt == CW'(BURST_LEN - 1));
  wire ack_slot = (bitn == 4'd8);
  wire tx_st    = (st == S_DEVW) || (st == S_MADDR) || (st == S_WDATA) || (st == S_DEVR);

  always_comb begin
    case (st)
      S_IDLE:            scl = 1'b1;
      S_STOP:            scl = (q != 2'd0);
      default:           scl = (q == 2'd1) || (q == 2'd2);
    endcase
    case (st)
      S_IDLE:            sda_pull = 1'b0;
      S_START, S_RSTART: sda_pull = q[1];
      S_STOP:            sda_pull = !q[1];
      S_RDATA:           sda_pull = ack_slot && !last;
      default:           sda_pull = tx_st && !ack_slot && !sh[7];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      qcnt <= '0;
      q <= '0;
      bitn <= '0;
      sh <= '0;
      addr_q <= '0;
      cnt <= '0;
      ack_n <= 1'b0;
      rd_mode <= 1'b0;
      wr_req <= 1'b0;
      rd_valid <= 1'b0;
      rd_data <= '0;
      done <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      rd_valid <= 1'b0;
      done <= 1'b0;
      if (st == S_IDLE) begin
        qcnt <= '0;
        q <= '0;
        bitn <= '0;
        if (start) begin
          rd_mode <= mode;
          addr_q <= mem_addr;
          st <= S_START;
        end
      end else begin
        qcnt <= tick ? '0 : qcnt + 1'b1;
        if (tick) q <= q + 2'd1;
        if (mid && ack_slot) ack_n <= sda_in;
        if (mid && st == S_RDATA && !ack_slot) sh <= {sh[6:0], sda_in};
        if (slot_end) begin
          case (st)
            S_START: begin
              sh <= {DEV_ADDR, 1'b0};
              bitn <= '0;
              st <= S_DEVW;
            end
            S_RSTART: begin
              sh <= {DEV_ADDR, 1'b1};
              bitn <= '0;
              st <= S_DEVR;
            end
            S_STOP: begin
              st <= S_IDLE;
              done <= 1'b1;
            end
            default: begin
              if (!ack_slot) begin
                bitn <= bitn + 4'd1;
                if (st != S_RDATA) sh <= sh << 1;
                else if (bitn == 4'd7) begin
                  rd_data <= sh;
                  rd_valid <= 1'b1;
                end
              end else begin
                bitn <= '0;
                case (st)
                  S_DEVW:
                    if (ack_n) st <= S_STOP;
                    else begin
                      sh <= addr_q;
                      st <= S_MADDR;
                    end
                  S_MADDR:
                    if (ack_n) st <= S_STOP;
                    else if (rd_mode) st <= S_RSTART;
                    else begin
                      sh <= wr_data;
                      wr_req <= 1'b1;
                      cnt <= '0;
                      st <= S_WDATA;
                    end
                  S_WDATA:
                    if (ack_n || last) st <= S_STOP;
                    else begin
                      sh <= wr_data;
                      wr_req <= 1'b1;
                      cnt <= cnt + 1'b1;
                    end
                  S_DEVR:
                    if (ack_n) st <= S_STOP;
                    else begin
                      cnt <= '0;
                      st <= S_RDATA;
                    end
                  S_RDATA:
                    if (last) st <= S_STOP;
                    else cnt <= cnt + 1'b1;
                  default: st <= S_STOP;
                endcase
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_burst_master_chk.sv
module i2c_burst_master_chk (
  input logic clk,
  input logic rst,
  input logic scl,
  input logic sda_pull,
  input logic wr_req,
  input logic rd_valid,
  input logic done
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (scl && !sda_pull && !done && !wr_req && !rd_valid));

  // R3: SDA and SCL never move together
  p_sda_apart_r3: assert property (@(posedge clk) disable iff (rst)
    $changed(sda_pull) |-> $stable(scl));

  // R2: SDA may only be pulled while SCL is high if SCL was already high
  p_start_edge_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull) && scl) |-> $past(scl));

  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_rd_low_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !scl);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_free_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (scl && !sda_pull));
endmodule

bind i2c_burst_master i2c_burst_master_chk u_chk (
  .clk(clk), .rst(rst), .scl(scl), .sda_pull(sda_pull),
  .wr_req(wr_req), .rd_valid(rd_valid), .done(done)
);

// File: tb/sim_i2c_burst_master.sv
module sim_i2c_burst_master;
  localparam int Q = 4;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, mode = 1'b0;
  logic [7:0] mem_addr = '0, wr_data = '0;
  logic wr_req, rd_valid, done, scl, sda_pull;
  logic [7:0] rd_data;
  logic s_pull = 1'b0;
  wire  sda_w = ~(sda_pull | s_pull);

  i2c_burst_master #(.QUARTER(Q), .BURST_LEN(N)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .mem_addr(mem_addr),
    .wr_data(wr_data), .wr_req(wr_req), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .scl(scl), .sda_pull(sda_pull), .sda_in(sda_w)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory-device model and bus monitor, on the falling clock edge
  logic [7:0] mem [256];
  logic [7:0] rx_log [32];
  logic [7:0] rd_log [32];
  logic       mack_log [32];
  logic [7:0] rsh, tx, ptr;
  int rx_n, rd_n, mack_n, wr_n, done_n, starts, stops, per_bad, cyc, last_rise;
  int sst, bc;
  logic in_ack, mdone, pscl, psda, nack_dev, nack_maddr;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    {rx_n, rd_n, mack_n, wr_n, done_n, starts, stops, per_bad, cyc, last_rise} = '0;
    sst = 0; bc = 0; in_ack = 0; mdone = 0; pscl = 1; psda = 1;
    nack_dev = 0; nack_maddr = 0; rsh = 0; tx = 0; ptr = 0;
  end

  always @(negedge clk) begin
    logic cs;
    cs = sda_w;
    cyc++;
    if (wr_req) begin wr_n++; wr_data <= wr_data + 8'd1; end
    if (rd_valid) begin rd_log[rd_n[4:0]] = rd_data; rd_n++; end
    if (done) done_n++;
    if (!rst) begin
      if (pscl && scl && psda && !cs) begin
        starts++; sst = 1; bc = 0; in_ack = 0; mdone = 0; s_pull = 0;
      end else if (pscl && scl && !psda && cs) begin
        stops++; sst = 0; s_pull = 0;
      end else if (!pscl && scl) begin
        if (last_rise != 0 && cyc - last_rise != 4 * Q) per_bad++;
        last_rise = cyc;
        if (sst >= 1 && sst <= 3 && bc < 8) begin rsh = {rsh[6:0], cs}; bc++; end
        else if (sst == 4 && !in_ack) begin
          if (bc < 8) bc++;
          else begin mack_log[mack_n[4:0]] = cs; mack_n++; ptr++; mdone = 1; end
        end
      end else if (pscl && !scl) begin
        if (in_ack) begin
          in_ack = 0; s_pull = 0; bc = 0;
          if (sst == 4) begin tx = mem[ptr]; s_pull = !tx[7]; end
        end else if (sst >= 1 && sst <= 3 && bc == 8) begin
          rx_log[rx_n[4:0]] = rsh; rx_n++; in_ack = 1;
          case (sst)
            1: if (rsh == 8'hA0) begin s_pull = !nack_dev; sst = nack_dev ? 0 : 2; end
               else if (rsh == 8'hA1) begin s_pull = 1; sst = 4; end
               else begin s_pull = 0; sst = 0; end
            2: begin ptr = rsh; s_pull = !nack_maddr; sst = nack_maddr ? 0 : 3; end
            default: begin mem[ptr] = rsh; ptr++; s_pull = 1; end
          endcase
        end else if (sst == 4) begin
          if (bc > 0 && bc < 8) s_pull = !tx[7 - bc];
          else if (bc == 8 && !mdone) s_pull = 0;
          else if (bc == 8 && mdone) begin
            mdone = 0;
            if (mack_log[mack_n[4:0] - 5'd1] == 1'b0) begin
              tx = mem[ptr]; bc = 0; s_pull = !tx[7];
            end else begin sst = 0; s_pull = 0; end
          end
        end
      end
    end
    pscl = scl;
    psda = cs;
  end

  task automatic run_burst(input logic m, input logic [7:0] a, input logic [7:0] first);
    @(negedge clk);
    {rx_n, rd_n, mack_n, wr_n, done_n, starts, stops, per_bad, last_rise} = '0;
    wr_data = first; mode = m; mem_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000 && done_n == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 scl", int'(scl), 1);
    check("R1 sda_pull", int'(sda_pull), 0);
    check("R1 done", int'(done), 0);
    check("R1 wr_req", int'(wr_req), 0);
    check("R1 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_write(input logic [7:0] a, input logic [7:0] first);
    run_burst(1'b0, a, first);
    check("R4 byte count", rx_n, N + 2);
    check("R4 device byte", int'(rx_log[0]), 8'hA0);
    check("R4 address byte", int'(rx_log[1]), int'(a));
    for (int i = 0; i < N; i++) check("R4 R5 payload", int'(rx_log[i + 2]), int'(8'(first + i)));
    check("R5 wr_req count", wr_n, N);
    check("R2 starts", starts, 1);
    check("R2 stops", stops, 1);
    check("R3 scl period", per_bad, 0);
    check("R9 done count", done_n, 1);
    check("R2 bus idle", int'(scl && sda_w), 1);
  endtask

  task automatic t_read(input logic [7:0] a, input logic [7:0] first, input int valid_n);
    run_burst(1'b1, a, 8'h00);
    check("R6 header count", rx_n, 3);
    check("R6 device write", int'(rx_log[0]), 8'hA0);
    check("R6 address", int'(rx_log[1]), int'(a));
    check("R6 device read", int'(rx_log[2]), 8'hA1);
    check("R6 repeated start", starts, 2);
    check("R6 rd_valid count", rd_n, N);
    for (int i = 0; i < N; i++)
      check("R10 readback", int'(rd_log[i]), (i < valid_n) ? int'(8'(first + i)) : 0);
    check("R7 master acks", mack_n, N);
    for (int i = 0; i < N; i++) check("R7 ack bit", int'(mack_log[i]), (i == N - 1) ? 1 : 0);
    check("R2 stops", stops, 1);
    check("R3 scl period", per_bad, 0);
    check("R9 done count", done_n, 1);
  endtask

  task automatic t_abort(input logic m, input logic dev);
    nack_dev = dev; nack_maddr = !dev;
    run_burst(m, 8'h10, 8'h55);
    nack_dev = 0; nack_maddr = 0;
    check("R8 bytes sent", rx_n, dev ? 1 : 2);
    check("R8 no wr_req", wr_n, 0);
    check("R8 no rd_valid", rd_n, 0);
    check("R8 stop", stops, 1);
    check("R8 single start", starts, 1);
    check("R8 done", done_n, 1);
    check("R8 bus idle", int'(scl && sda_w), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write(8'h20, 8'h01);
    t_read(8'h20, 8'h01, N);
    t_read(8'h25, 8'h06, 5);
    t_write(8'hFB, 8'hC3);
    t_read(8'hFB, 8'hC3, N);
    t_abort(1'b0, 1'b1);
    t_abort(1'b1, 1'b0);
    t_read(8'h20, 8'h01, N);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule